// File: doc/BRIEF.md
# Bit-Oriented Frame CRC and Residue Checker

This block sits in the receive path of a bit-oriented link, after flag detection and zero-bit removal. It takes one data bit per accepted strobe and packs the bits into characters of a selectable length of 5 to 8 bits. Over the same bits it runs a 16-bit CRC. When a closing flag is signalled, it closes the frame. It raises an end-of-frame pulse, reports whether the CRC remainder matched the fixed good value, and gives a 3-bit residue code.

A frame may end on any bit, not only on a character boundary. The last 16 bits before the closing flag are the sender's inverted CRC and carry no data. The residue code tells a downstream reader how many bits the final partial character holds, so it can locate the boundary between data and CRC in the last characters it received. An abort strobe drops the frame in progress and produces no result for it.

Top module: `frame_check_rx`

## Requirements
- R1: Each accepted bit (`bit_valid` high with neither `flag_close` nor `abort` high) is placed at the next free position of the current character, least significant bit first. The character length is 5 + `len_sel` bits (`len_sel` 0..3 selects 5, 6, 7 or 8 bits). The cycle after the bit that fills a character, `char_valid` is high for one cycle and `char_data` holds that character, with every bit above the character length at zero.
- R2: The CRC register is set to all ones at reset, after a closing flag and after an abort. It is updated once per accepted bit with the polynomial x^16 + x^12 + x^5 + 1, most significant end first. A bit that arrives in the same cycle as `flag_close` is not data and does not enter the CRC or the character.
- R3: One cycle after a `flag_close` without `abort`, `eof` is high for one cycle. In that same cycle `crc_err` is high exactly when the CRC register differs from 16'h1D0F or the frame is short (R7). `crc_err` is never high without `eof`.
- R4: With `eof`, `residue` takes the value (p + 3) mod 8. Here p is the number of bits (CRC bits included) left in the unfinished character at the closing flag, that is, the total bit count modulo the character length. A frame with no partial character therefore gives 3'b011.
- R5: When p is nonzero, the partial character is delivered on `char_valid`/`char_data` in the same cycle as `eof`, right-aligned with its upper bits zero. When p is zero, no character strobe goes with `eof`.
- R6: `residue` holds its value until the first accepted bit of the next frame. One cycle after that bit it reads 0.
- R7: A frame closed after fewer than 16 accepted bits raises `short_frame` and `crc_err` together with `eof`. A frame of 16 or more bits never raises `short_frame`.
- R8: `abort` discards the frame in progress. No `eof` follows it, even when `flag_close` is high in the same cycle. The CRC, the character and the bit count all restart, so the next frame is judged on its own.
- R9: While `rst` is high and in the first cycle after it, `char_valid`, `char_data`, `eof`, `crc_err`, `short_frame` and `residue` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | A received data bit is present on `bit_data` |
| bit_data | input | 1 | Received data bit |
| flag_close | input | 1 | Closing flag detected; ends the frame |
| abort | input | 1 | Abort detected; discards the frame |
| len_sel | input | SEL_W (2) | Character length select, length = 5 + value |
| char_valid | output | 1 | One-cycle strobe for an assembled character |
| char_data | output | MAXW (8) | Assembled character, LSB first received |
| eof | output | 1 | One-cycle end-of-frame pulse |
| crc_err | output | 1 | CRC check failed, valid with `eof` |
| short_frame | output | 1 | Frame shorter than 16 bits, valid with `eof` |
| residue | output | 3 | Residue code of the last frame |

## Verification
Two things can land on the same edge: the end of a frame and the delivery of a character. The end of a frame also competes with the inputs that would cancel it. The bench sweeps every character length against frames of 8n+k data bits for each k from 0 to 7. This places the closing flag both on a character boundary and at every offset inside a character. Every frame must give exactly the expected character stream, and a partial character must arrive in the `eof` cycle only when one exists. The bench also drives a data bit in the closing-flag cycle, and an abort in the closing-flag cycle. These are judged by a CRC pass on the later good frame and by the absence of any `eof`.

// File: rtl/frame_check_pkg.sv
package frame_check_pkg;
  localparam int RES_W    = 3;
  localparam int RES_BIAS = 3;
endpackage

// File: rtl/frame_crc_reg.sv
module frame_crc_reg #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   POLY = 16'h1021,
  parameter logic [W-1:0]   INIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic         fb;
  logic [W-1:0] crc_nxt;

  always_comb begin
    fb      = crc[W-1] ^ din;
    crc_nxt = {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) crc <= INIT;
    else if (step)    crc <= crc_nxt;
  end
endmodule

// File: rtl/frame_char_pack.sv
module frame_char_pack #(
  parameter int MAXW = 8,
  parameter int CW   = $clog2(MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            step,
  input  logic            din,
  input  logic [CW-1:0]   len,
  output logic            full,
  output logic [CW-1:0]   cnt,
  output logic [MAXW-1:0] word,
  output logic [MAXW-1:0] word_next
);
  // place the incoming bit at the current fill position
  for (genvar i = 0; i < MAXW; i++) begin : g_slot
    assign word_next[i] = (cnt == CW'(i)) ? din : word[i];
  end

  assign full = step && (CW'(cnt + 1'b1) == len);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt  <= '0;
      word <= '0;
    end else if (step) begin
      if (full) begin
        cnt  <= '0;
        word <= '0;
      end else begin
        cnt  <= CW'(cnt + 1'b1);
        word <= word_next;
      end
    end
  end
endmodule

// File: rtl/frame_len_count.sv
module frame_len_count #(
  parameter int LIMIT = 16,
  parameter int NW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic empty,
  output logic reached
);
  logic [NW-1:0] n;

  assign empty   = (n == '0);
  assign reached = (n == NW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clear)          n <= '0;
    else if (step && !reached) n <= NW'(n + 1'b1);
  end
endmodule

// File: rtl/frame_check_rx.sv
module frame_check_rx
  import frame_check_pkg::*;
#(
  parameter int               MAXW  = 8,
  parameter int               SEL_W = 2,
  parameter int               CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY  = 16'h1021,
  parameter logic [CRC_W-1:0] GOOD  = 16'h1D0F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             bit_data,
  input  logic             flag_close,
  input  logic             abort,
  input  logic [SEL_W-1:0] len_sel,
  output logic             char_valid,
  output logic [MAXW-1:0]  char_data,
  output logic             eof,
  output logic             crc_err,
  output logic             short_frame,
  output logic [RES_W-1:0] residue
);
  localparam int CW      = $clog2(MAXW + 1);
  localparam int MIN_LEN = MAXW - (1 << SEL_W) + 1;

  logic             acc, end_ok, clr;
  logic [CW-1:0]    len;
  logic             full;
  logic [CW-1:0]    cnt;
  logic [MAXW-1:0]  word, word_next;
  logic [CRC_W-1:0] crc;
  logic             fresh, long_enough;
  logic [CW:0]      rsum;

  assign acc    = bit_valid && !flag_close && !abort;
  assign end_ok = flag_close && !abort;
  assign clr    = flag_close || abort;
  assign len    = CW'(MIN_LEN) + CW'(len_sel);
  assign rsum   = {1'b0, cnt} + (CW+1)'(RES_BIAS);

  frame_crc_reg #(.W(CRC_W), .POLY(POLY), .INIT('1)) crc_i (
    .clk(clk), .rst(rst), .clear(clr), .step(acc), .din(bit_data), .crc(crc)
  );

  frame_char_pack #(.MAXW(MAXW), .CW(CW)) pack_i (
    .clk(clk), .rst(rst), .clear(clr), .step(acc), .din(bit_data), .len(len),
    .full(full), .cnt(cnt), .word(word), .word_next(word_next)
  );

  frame_len_count #(.LIMIT(CRC_W)) lenc_i (
    .clk(clk), .rst(rst), .clear(clr), .step(acc),
    .empty(fresh), .reached(long_enough)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      char_valid  <= 1'b0;
      char_data   <= '0;
      eof         <= 1'b0;
      crc_err     <= 1'b0;
      short_frame <= 1'b0;
      residue     <= '0;
    end else begin
      char_valid  <= (acc && full) || (end_ok && cnt != '0);
      eof         <= end_ok;
      crc_err     <= end_ok && ((crc != GOOD) || !long_enough);
      short_frame <= end_ok && !long_enough;
      if (acc && full)
        char_data <= word_next;
      else if (end_ok && cnt != '0)
        char_data <= word;
      if (end_ok)
        residue <= rsum[RES_W-1:0];
      else if (acc && fresh)
        residue <= '0;
    end
  end
endmodule

// File: rtl/frame_check_rx_sva.sv
module frame_check_rx_sva #(
  parameter int MAXW  = 8,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_valid,
  input logic             flag_close,
  input logic             abort,
  input logic [SEL_W-1:0] len_sel,
  input logic             char_valid,
  input logic [MAXW-1:0]  char_data,
  input logic             eof,
  input logic             crc_err,
  input logic             short_frame,
  input logic [2:0]       residue
);
  localparam int MIN_LEN = MAXW - (1 << SEL_W) + 1;

  logic [MAXW-1:0] hi_mask;
  always_comb hi_mask = {MAXW{1'b1}} << (MIN_LEN + int'(len_sel));

  assert_eof_after_flag_R3: assert property (@(posedge clk) disable iff (rst)
    eof |-> $past(flag_close && !abort));
  assert_err_with_eof_R3: assert property (@(posedge clk) disable iff (rst)
    crc_err |-> eof);
  assert_short_is_err_R7: assert property (@(posedge clk) disable iff (rst)
    short_frame |-> crc_err);
  assert_abort_no_eof_R8: assert property (@(posedge clk) disable iff (rst)
    abort |=> !eof);
  assert_residue_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!flag_close && !bit_valid) |=> $stable(residue));
  assert_char_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    char_valid |-> ((char_data & $past(hi_mask)) == '0));
endmodule

bind frame_check_rx frame_check_rx_sva #(.MAXW(MAXW), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst(rst), .bit_valid(bit_valid), .flag_close(flag_close),
  .abort(abort), .len_sel(len_sel), .char_valid(char_valid),
  .char_data(char_data), .eof(eof), .crc_err(crc_err),
  .short_frame(short_frame), .residue(residue)
);

// File: tb/frame_check_rx_tb_top.sv
module frame_check_rx_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int          MAXW = 8;
  localparam logic [15:0] GOOD = 16'h1D0F;

  logic       clk = 1'b0, rst = 1'b1;
  logic       bit_valid = 1'b0, bit_data = 1'b0, flag_close = 1'b0, abort = 1'b0;
  logic [1:0] len_sel = 2'd0;
  logic       char_valid, eof, crc_err, short_frame;
  logic [MAXW-1:0] char_data;
  logic [2:0] residue;

  frame_check_rx dut_i (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data),
    .flag_close(flag_close), .abort(abort), .len_sel(len_sel),
    .char_valid(char_valid), .char_data(char_data), .eof(eof),
    .crc_err(crc_err), .short_frame(short_frame), .residue(residue)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, eof_cnt = 0;
  bit chk_chars = 1'b1;
  logic [MAXW-1:0] exp_q[$];
  logic [MAXW-1:0] exp_c;
  logic exp_err = 1'b0, exp_short = 1'b0;
  logic [2:0] exp_res = 3'd0;
  logic [15:0] lfsr = 16'hACE1;
  logic fbits[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: outputs are registered, sampled on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (char_valid && chk_chars) begin
        if (exp_q.size() == 0) check(1'b0, "R1", "unexpected character", char_data, 0);
        else begin
          exp_c = exp_q.pop_front();
          check(char_data == exp_c, "R1", "character value", char_data, exp_c);
        end
      end
      if (eof) begin
        eof_cnt++;
        check(crc_err == exp_err, "R3", "crc_err at eof", crc_err, exp_err);
        check(short_frame == exp_short, "R7", "short_frame at eof", short_frame, exp_short);
        check(residue == exp_res, "R4", "residue code", residue, exp_res);
        if (chk_chars)
          check(exp_q.size() == 0, "R5", "characters missing at eof", exp_q.size(), 0);
      end
    end
  end

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic b);
    logic fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  task automatic get_rand(output logic b);
    lfsr = lfsr[0] ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
    b = lfsr[0];
  endtask

  // data bits, optionally followed by the inverted CRC, most significant end first
  task automatic build_frame(input int nd, input bit app_crc);
    logic [15:0] c = 16'hFFFF;
    logic b;
    fbits.delete();
    for (int i = 0; i < nd; i++) begin
      get_rand(b);
      fbits.push_back(b);
      c = crc_upd(c, b);
    end
    if (app_crc) for (int i = 15; i >= 0; i--) fbits.push_back(~c[i]);
  endtask

  task automatic expect_frame(input int sel, input bit known_good);
    int L = 5 + sel;
    int p = 0;
    logic [MAXW-1:0] w = '0;
    logic [15:0] c = 16'hFFFF;
    foreach (fbits[i]) begin
      w[p] = fbits[i];
      c = crc_upd(c, fbits[i]);
      p++;
      if (p == L) begin exp_q.push_back(w); w = '0; p = 0; end
    end
    if (p != 0) exp_q.push_back(w);
    exp_res   = 3'((p + 3) % 8);
    exp_short = (fbits.size() < 16);
    exp_err   = known_good ? 1'b0 : ((c != GOOD) || exp_short);
  endtask

  task automatic drive_bits(input bit gaps);
    foreach (fbits[i]) begin
      if (gaps && (i % 5 == 2)) begin
        @(negedge clk); bit_valid = 1'b0; bit_data = 1'b1;
      end
      @(negedge clk); bit_valid = 1'b1; bit_data = fbits[i];
    end
  endtask

  task automatic run_frame(input int sel, input int nd, input bit app_crc,
                           input bit flip, input bit gaps, input bit flag_bit);
    int e0;
    len_sel = 2'(sel);
    build_frame(nd, app_crc);
    if (flip) fbits[3] = ~fbits[3];
    expect_frame(sel, app_crc && !flip);
    e0 = eof_cnt;
    drive_bits(gaps);
    // R2: a bit presented with the closing flag must not be taken as data
    @(negedge clk); bit_valid = flag_bit; bit_data = 1'b1; flag_close = 1'b1;
    @(negedge clk); bit_valid = 1'b0; flag_close = 1'b0;
    repeat (2) @(negedge clk);
    check(eof_cnt == e0 + 1, "R3", "one eof per frame", eof_cnt - e0, 1);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e0;
    repeat (4) @(negedge clk);
    check({char_valid, char_data, eof, crc_err, short_frame, residue} == '0,
          "R9", "outputs in reset", {char_valid, char_data, eof, crc_err, short_frame, residue}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({char_valid, eof, crc_err, residue} == '0, "R9", "outputs after reset",
          {char_valid, eof, crc_err, residue}, 0);

    // R1 R2 R4 R5: every length against every bit offset, good frames
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 8; k++)
        for (int n = 1; n <= 2; n++)
          run_frame(s, 8 * n + k, 1'b1, 1'b0, k[0], n == 2);

    // R3: corrupted frames must fail
    for (int s = 0; s < 4; s++) run_frame(s, 20 + s, 1'b1, 1'b1, 1'b0, 1'b0);

    // R7: short and boundary lengths without an appended CRC
    run_frame(3, 10, 1'b0, 1'b0, 1'b0, 1'b0);
    run_frame(0, 15, 1'b0, 1'b0, 1'b0, 1'b0);
    run_frame(1, 16, 1'b0, 1'b0, 1'b0, 1'b0);
    run_frame(2, 0, 1'b1, 1'b0, 1'b0, 1'b0);

    // R6: residue holds, then clears on the next frame's first bit
    run_frame(2, 13, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    check(residue == exp_res, "R6", "residue held", residue, exp_res);
    chk_chars = 1'b0;
    bit_valid = 1'b1; bit_data = 1'b1;
    @(negedge clk); bit_valid = 1'b0;
    check(residue == 3'd0, "R6", "residue cleared by new frame", residue, 0);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;

    // R8: abort mid-frame gives no eof, next frame is judged on its own
    len_sel = 2'd3;
    build_frame(30, 1'b0);
    e0 = eof_cnt;
    drive_bits(1'b0);
    @(negedge clk); bit_valid = 1'b0; abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    repeat (3) @(negedge clk);
    check(eof_cnt == e0, "R8", "no eof after abort", eof_cnt - e0, 0);

    // R8: abort together with closing flag
    build_frame(21, 1'b1);
    drive_bits(1'b0);
    @(negedge clk); bit_valid = 1'b0; abort = 1'b1; flag_close = 1'b1;
    @(negedge clk); abort = 1'b0; flag_close = 1'b0;
    repeat (3) @(negedge clk);
    check(eof_cnt == e0, "R8", "abort beats flag", eof_cnt - e0, 0);
    exp_q.delete();
    chk_chars = 1'b1;
    run_frame(3, 27, 1'b1, 1'b0, 1'b0, 1'b0);
    run_frame(0, 22, 1'b1, 1'b0, 1'b1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule